// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is a single PWM timer channel built around a down-counter. Software-side values (a period value and a compare value) sit in buffer inputs; the channel keeps its own active counter and active compare registers, which take new values only when a manual load strobe is given or, with auto-reload enabled, when the counter underflows. Writes to the buffers therefore take effect at a clean period boundary.

The counter steps down by one on each cycle in which the tick enable is high and the channel is running. The raw output level is high while the counter is at or below the active compare value, and an invert control is applied after that comparison. An all-ones compare value gives a permanently high raw level; a zero duty cycle cannot be produced. Clearing auto-reload lets the current period run out, after which the channel parks: the output falls, except when the compare value is all ones, in which case it stays high until a manual load brings new values.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: After a manual load of period value N (N >= 1), the counter steps N, N-1, ..., 0 on successive enabled ticks, so one period lasts N+1 ticks; with the tick enable high every other cycle the period lasts 2(N+1) clock cycles.
- R2: The raw level is high while the active counter is at or below the active compare value C and low above it, giving min(C,N)+1 high ticks out of N+1 per period.
- R3: An all-ones compare value gives a raw level that is high for every tick of the period.
- R4: A high `load_now` copies both buffers into the active registers at the next clock edge, takes priority over an underflow reload in that cycle, and restarts a parked channel.
- R5: With auto-reload set, the buffers are copied into the active registers when the counter underflows; a buffer change made during a period leaves the current period unchanged and applies from the next.
- R6: With auto-reload clear, an underflow parks the channel: no further counting or period pulses; the raw level is then low unless the active compare value is all ones, in which case it stays high.
- R7: `pwm_out` equals the raw level XOR `invert`.
- R8: While `run` or `tick` is low (and no manual load), the counter holds, no reload happens and the output does not change.
- R9: `period_end` is a single-cycle pulse, high in the cycle after each underflow edge.
- R10: After reset the channel is parked with active counter and compare at 0, `pwm_out` equals `invert` and `period_end` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counting allowed |
| load_now | input | 1 | Manual load strobe of both buffers |
| invert | input | 1 | Output polarity flip |
| auto_reload | input | 1 | Reload buffers at underflow |
| period_buf | input | W | Period buffer value (ticks minus one) |
| compare_buf | input | W | Compare buffer value |
| tick | input | 1 | Tick enable from the clock stage |
| pwm_out | output | 1 | PWM output |
| period_end | output | 1 | One-cycle pulse after each underflow |

## Verification
The assertions take for granted that any period value reaching the active counter is at least 1, since a zero period would make underflows back-to-back and break the single-pulse property; the stimulus only ever loads period values from 1 upward. They also assume the buffers are held steady on the edge a load happens, which the bench guarantees by changing inputs only at falling edges. The sweeps cover every compare value from 0 up to and past the period value, plus all-ones, for both polarities.

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load_now,
  input  logic         invert,
  input  logic         auto_reload,
  input  logic [W-1:0] period_buf,
  input  logic [W-1:0] compare_buf,
  input  logic         tick,
  output logic         pwm_out,
  output logic         period_end
);

  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] cnt_q, cmp_q;
  logic         parked_q, pend_q;
  logic         step, at_zero, underflow, raw_lvl;

  assign step      = run && tick && !parked_q && !load_now;
  assign at_zero   = (cnt_q == '0);
  assign underflow = step && at_zero;
  assign raw_lvl   = parked_q ? (cmp_q == ALL_ONES) : (cnt_q <= cmp_q);
  assign pwm_out   = raw_lvl ^ invert;
  assign period_end = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cmp_q    <= '0;
      parked_q <= 1'b1;
      pend_q   <= 1'b0;
    end else begin
      pend_q <= underflow;
      if (load_now) begin
        cnt_q    <= period_buf;
        cmp_q    <= compare_buf;
        parked_q <= 1'b0;
      end else if (underflow) begin
        if (auto_reload) begin
          cnt_q <= period_buf;
          cmp_q <= compare_buf;
        end else begin
          parked_q <= 1'b1;
        end
      end else if (step) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_count_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_manual_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (cnt_q == $past(period_buf) && cmp_q == $past(compare_buf) && !parked_q));

  assert_parked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    parked_q |=> !period_end);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run && tick) && !load_now) |=> ($stable(cnt_q) && $stable(cmp_q)));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !period_end);

  assert_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(invert) && $stable(cnt_q) && $stable(cmp_q) && $stable(parked_q) |-> $changed(pwm_out));

endmodule

// File: tb/pwm_dbuf_chan_bench.sv
module pwm_dbuf_chan_bench;
  localparam int W = 16;
  logic clk = 0, rst_n = 0;
  logic run = 0, load_now = 0, invert = 0, auto_reload = 0, tick = 0;
  logic [W-1:0] period_buf = '0, compare_buf = '0;
  logic pwm_out, period_end;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  pwm_dbuf_chan #(.W(W)) u_pwm_dbuf_chan (
    .clk(clk), .rst_n(rst_n), .run(run), .load_now(load_now), .invert(invert),
    .auto_reload(auto_reload), .period_buf(period_buf), .compare_buf(compare_buf),
    .tick(tick), .pwm_out(pwm_out), .period_end(period_end));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pe(output bit seen);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (period_end) begin seen = 1; break; end
    end
  endtask

  task automatic measure_period(output int len, output int hi);
    len = 0; hi = 0;
    do begin
      hi += int'(pwm_out);
      len++;
      @(negedge clk);
    end while (!period_end && len < 300);
  endtask

  task automatic start(input int n, input int c);
    period_buf = W'(n); compare_buf = W'(c);
    auto_reload = 1; run = 1; tick = 1; load_now = 1;
    @(negedge clk);
    load_now = 0;
  endtask

  task automatic sweep_one(input int n, input int c, input bit inv);
    bit seen; int len, hi, raw;
    invert = inv;
    start(n, c);
    wait_pe(seen);
    measure_period(len, hi);
    raw = (c >= n) ? n + 1 : c + 1;
    check(seen && len == n + 1, "R1 period length", len, n + 1);
    if (c == 16'hFFFF)
      check(hi == (inv ? 0 : n + 1), "R3 full duty", hi, inv ? 0 : n + 1);
    else
      check(hi == (inv ? n + 1 - raw : raw), inv ? "R7 inverted duty" : "R2 duty",
            hi, inv ? n + 1 - raw : raw);
  endtask

  initial begin
    #(8 * 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit seen; int len, hi, pe_cnt; logic held;
    repeat (3) @(negedge clk);
    check(pwm_out == 0 && period_end == 0, "R10 reset state", pwm_out, 0);
    rst_n = 1;
    @(negedge clk);
    invert = 1;
    @(negedge clk);
    check(pwm_out == 1, "R10 parked output follows invert", pwm_out, 1);

    for (int inv = 0; inv < 2; inv++)
      for (int n = 1; n <= 6; n++) begin
        for (int c = 0; c <= n + 1; c++) sweep_one(n, c, inv[0]);
        sweep_one(n, 16'hFFFF, inv[0]);
      end
    invert = 0;

    // R1: tick every other cycle
    start(3, 1);
    fork
      begin
        for (int i = 0; i < 60; i++) begin tick = ~tick; @(negedge clk); end
      end
      begin
        wait_pe(seen); measure_period(len, hi);
        check(len == 8, "R1 half-rate period", len, 8);
      end
    join
    tick = 1;

    // R5: buffer change mid-period takes effect at next boundary
    start(3, 0);
    wait_pe(seen);
    @(negedge clk);
    period_buf = 6;
    len = 1;
    while (!period_end && len < 100) begin len++; @(negedge clk); end
    check(len == 4, "R5 current period unchanged", len, 4);
    measure_period(len, hi);
    check(len == 7, "R5 next period uses new buffer", len, 7);

    // R6: stop with partial duty -> output low, no pulses
    start(3, 1);
    wait_pe(seen);
    auto_reload = 0;
    wait_pe(seen);
    check(seen, "R6 final period completes", seen, 1);
    pe_cnt = 0; hi = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); pe_cnt += int'(period_end); hi += int'(pwm_out);
    end
    check(pe_cnt == 0, "R6 no pulses after stop", pe_cnt, 0);
    check(hi == 0, "R6 output low after stop", hi, 0);

    // R6: stop at full duty -> stays high; R4 manual load drops it
    start(4, 16'hFFFF);
    wait_pe(seen);
    auto_reload = 0;
    wait_pe(seen);
    hi = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); hi += int'(pwm_out); end
    check(hi == 12, "R6 full duty stays high when parked", hi, 12);
    period_buf = 4; compare_buf = 0; load_now = 1;
    @(negedge clk);
    load_now = 0;
    check(pwm_out == 0, "R4 manual load drops output", pwm_out, 0);
    wait_pe(seen);
    check(seen, "R4 manual load restarts parked channel", seen, 1);

    // R8: run low holds
    start(5, 2);
    repeat (2) @(negedge clk);
    run = 0;
    held = pwm_out; pe_cnt = 0; hi = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); pe_cnt += int'(period_end); hi += int'(pwm_out != held);
    end
    check(pe_cnt == 0 && hi == 0, "R8 run low holds", pe_cnt + hi, 0);
    run = 1; tick = 0;
    held = pwm_out; pe_cnt = 0; hi = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); pe_cnt += int'(period_end); hi += int'(pwm_out != held);
    end
    check(pe_cnt == 0 && hi == 0, "R8 tick low holds", pe_cnt + hi, 0);
    tick = 1;

    // R9: pulse is one cycle wide
    wait_pe(seen);
    @(negedge clk);
    check(seen && !period_end, "R9 single-cycle pulse", period_end, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule